// File: doc/BRIEF.md
# Privileged System Register Access Controller

This block owns two 64-bit memory-attribute registers: one belonging to the guest operating system and one belonging to the hypervisor. Each register is eight one-byte attribute fields. The block takes system-register read and write requests. Each request carries an encoded register identifier, the current privilege level (0 to 3) and a set of virtualization control bits. For each request it decides where the access goes: the guest register, the hypervisor register, a memory-backed shadow slot, a trap to privilege level 2, or an undefined-instruction outcome.

The guest register can be reached under two identifiers. The direct identifier is the normal one. The alias identifier is used by a hypervisor running in host mode. The outcome of every request is registered and appears one clock later. A shadow redirect is shown as a request on a simple memory-style port and is not served internally.

A combinational lookup port returns one attribute byte, selected by a 3-bit index, from the register that governs the current translation regime.

Top module: `sysreg_attr_ctrl`

## Requirements
- R1: A request at privilege level 0 is undefined, whichever identifier it uses.
- R2: A direct-identifier request at level 1 traps to level 2 with syndrome class 0x18 when level 2 is enabled and running 64-bit. For a read, the trap also needs the read-trap control set. For a write, it needs the write-trap control set.
- R3: A direct-identifier request at level 1 that does not trap goes to the shadow port when level 2 is enabled and 64-bit and the nesting bits {n2,n1,n0} equal 3'b111. The shadow port shows offset 0x140, the write flag and the write data.
- R4: Any other direct-identifier request at level 1 reaches the guest register.
- R5: A direct-identifier request at level 2 reaches the hypervisor register when host mode is 1, and the guest register when host mode is 0. At level 3 it always reaches the guest register.
- R6: An alias-identifier request at level 1 with level 2 enabled is handled in priority order. Nesting bits equal to 3'b101 give a shadow redirect at offset 0x140. Otherwise n0 = 1 gives a trap with class 0x18. Any other alias request at level 1 is undefined.
- R7: An alias-identifier request at level 2 or level 3 reaches the guest register only when level 2 is enabled and host mode is 1. Otherwise it is undefined.
- R8: The direct identifier is op0=2'b11, op1=3'b000, CRn=4'b1010, CRm=4'b0010, op2=3'b000. The alias identifier differs only in op1=3'b101. Any other identifier is undefined.
- R9: Each request gets exactly one response, one clock later. The response kind is one-hot: bit 0 is done, bit 1 is trap, bit 2 is undefined and bit 3 is shadow. With no request, rsp_valid and all kind bits are 0.
- R10: A write changes a register only when its outcome is done. The change takes effect on the response edge. A read that completes returns the register value from before that edge.
- R11: After reset, both registers are all zeros and no response is valid.
- R12: The lookup port returns bits [8n+7:8n] for index n. It reads the hypervisor register when the current level is 2 and host mode is 1, and the guest register otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Identifier field op0 |
| req_op1 | input | 3 | Identifier field op1 |
| req_crn | input | 4 | Identifier field CRn |
| req_crm | input | 4 | Identifier field CRm |
| req_op2 | input | 3 | Identifier field op2 |
| req_wdata | input | 64 | Write data |
| cur_pl | input | 2 | Current privilege level |
| pl2_enabled | input | 1 | Level 2 is enabled |
| pl2_is64 | input | 1 | Level 2 runs 64-bit |
| host_mode | input | 1 | Hypervisor host mode |
| trap_rd_ctl | input | 1 | Trap guest reads of the register |
| trap_wr_ctl | input | 1 | Trap guest writes of the register |
| nest_ctl | input | 3 | Nesting bits {n2,n1,n0} |
| rsp_valid | output | 1 | Response valid |
| rsp_kind | output | 4 | One-hot outcome: done, trap, undefined, shadow |
| rsp_rdata | output | 64 | Read data for a completed read |
| rsp_syndrome | output | 6 | Syndrome class for a trap |
| shadow_req | output | 1 | Shadow slot access request |
| shadow_write | output | 1 | Shadow access is a write |
| shadow_offset | output | 12 | Shadow slot offset |
| shadow_wdata | output | 64 | Shadow write data |
| lu_index | input | 3 | Attribute field index |
| lu_attr | output | 8 | Selected attribute byte |

## Verification
The assertions assume that every control input is a known 0 or 1 value on each clock edge where req_valid is high. They also assume that reset is held for at least one edge before the first request. The stimulus drives all request fields and controls together, half a cycle away from the sampling edge, and holds them stable across that edge. Random identifiers are biased toward the two valid encodings, and each control bit is drawn independently, so every routing branch is reached.

// File: rtl/sra_pkg.sv
package sra_pkg;
    localparam int REG_W   = 64;
    localparam int ATTR_W  = 8;
    localparam int N_ATTR  = REG_W / ATTR_W;
    localparam int IDX_W   = $clog2(N_ATTR);
    localparam int SYN_W   = 6;
    localparam int OFF_W   = 12;
    localparam int KIND_W  = 4;

    localparam int K_DONE   = 0;
    localparam int K_TRAP   = 1;
    localparam int K_UNDEF  = 2;
    localparam int K_SHADOW = 3;

    localparam logic [SYN_W-1:0] TRAP_CLASS = 6'h18;
    localparam logic [OFF_W-1:0] SHADOW_OFS = 12'h140;

    localparam logic [2:0] OP1_DIRECT = 3'b000;
    localparam logic [2:0] OP1_ALIAS  = 3'b101;

    typedef enum logic [1:0] {NAME_NONE, NAME_DIRECT, NAME_ALIAS} name_e;
    typedef enum logic [2:0] {RT_UNDEF, RT_TRAP, RT_SHADOW, RT_GUEST, RT_HYP} route_e;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysreg_id_t;

    typedef struct packed {
        logic       pl2_on;
        logic       pl2_64;
        logic       host_mode;
        logic       trap_rd;
        logic       trap_wr;
        logic [2:0] nest;
    } virt_ctl_t;

    function automatic name_e classify(sysreg_id_t id);
        name_e n;
        n = NAME_NONE;
        if (id.op0 == 2'b11 && id.crn == 4'b1010 && id.crm == 4'b0010 && id.op2 == 3'b000) begin
            if (id.op1 == OP1_DIRECT)     n = NAME_DIRECT;
            else if (id.op1 == OP1_ALIAS) n = NAME_ALIAS;
        end
        return n;
    endfunction

    function automatic logic [KIND_W-1:0] kind_of(route_e r);
        logic [KIND_W-1:0] k;
        k = '0;
        case (r)
            RT_TRAP:          k[K_TRAP]   = 1'b1;
            RT_SHADOW:        k[K_SHADOW] = 1'b1;
            RT_GUEST, RT_HYP: k[K_DONE]   = 1'b1;
            default:          k[K_UNDEF]  = 1'b1;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/sra_route.sv
module sra_route
    import sra_pkg::*;
(
    input  sysreg_id_t id,
    input  logic       is_write,
    input  logic [1:0] pl,
    input  virt_ctl_t  ctl,
    output route_e     route
);
    name_e name;
    logic  pl2_64on;
    logic  trap_hit;

    always_comb begin
        name     = classify(id);
        pl2_64on = ctl.pl2_on && ctl.pl2_64;
        trap_hit = pl2_64on && (is_write ? ctl.trap_wr : ctl.trap_rd);
        route    = RT_UNDEF;
        if (pl != 2'd0) begin
            case (name)
                NAME_DIRECT: begin
                    if (pl == 2'd1) begin
                        if (trap_hit)                               route = RT_TRAP;
                        else if (pl2_64on && ctl.nest == 3'b111)    route = RT_SHADOW;
                        else                                        route = RT_GUEST;
                    end else if (pl == 2'd2) begin
                        route = ctl.host_mode ? RT_HYP : RT_GUEST;
                    end else begin
                        route = RT_GUEST;
                    end
                end
                NAME_ALIAS: begin
                    if (pl == 2'd1) begin
                        if (ctl.pl2_on && ctl.nest == 3'b101)       route = RT_SHADOW;
                        else if (ctl.pl2_on && ctl.nest[0])         route = RT_TRAP;
                        else                                        route = RT_UNDEF;
                    end else if (ctl.pl2_on && ctl.host_mode) begin
                        route = RT_GUEST;
                    end
                end
                default: route = RT_UNDEF;
            endcase
        end
    end
endmodule

// File: rtl/sra_regbank.sv
module sra_regbank
    import sra_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_guest,
    input  logic              wr_hyp,
    input  logic [REG_W-1:0]  wdata,
    input  logic              lu_hyp_sel,
    input  logic [IDX_W-1:0]  lu_index,
    output logic [REG_W-1:0]  guest_q,
    output logic [REG_W-1:0]  hyp_q,
    output logic [ATTR_W-1:0] lu_attr
);
    logic [ATTR_W-1:0] guest_f [N_ATTR];
    logic [ATTR_W-1:0] hyp_f   [N_ATTR];

    always_ff @(posedge clk) begin
        if (rst) begin
            guest_q <= '0;
            hyp_q   <= '0;
        end else begin
            if (wr_guest) guest_q <= wdata;
            if (wr_hyp)   hyp_q   <= wdata;
        end
    end

    for (genvar n = 0; n < N_ATTR; n++) begin : g_field
        assign guest_f[n] = guest_q[n*ATTR_W +: ATTR_W];
        assign hyp_f[n]   = hyp_q[n*ATTR_W +: ATTR_W];
    end

    assign lu_attr = lu_hyp_sel ? hyp_f[lu_index] : guest_f[lu_index];

    // R10: contents move only on a write strobe
    a_r10_guest_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_guest |=> $stable(guest_q));
    a_r10_hyp_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_hyp |=> $stable(hyp_q));
    a_r10_single_target: assert property (@(posedge clk) disable iff (rst)
        !(wr_guest && wr_hyp));
endmodule

// File: rtl/sysreg_attr_ctrl.sv
module sysreg_attr_ctrl
    import sra_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_op0,
    input  logic [2:0]  req_op1,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_op2,
    input  logic [63:0] req_wdata,
    input  logic [1:0]  cur_pl,
    input  logic        pl2_enabled,
    input  logic        pl2_is64,
    input  logic        host_mode,
    input  logic        trap_rd_ctl,
    input  logic        trap_wr_ctl,
    input  logic [2:0]  nest_ctl,
    output logic        rsp_valid,
    output logic [3:0]  rsp_kind,
    output logic [63:0] rsp_rdata,
    output logic [5:0]  rsp_syndrome,
    output logic        shadow_req,
    output logic        shadow_write,
    output logic [11:0] shadow_offset,
    output logic [63:0] shadow_wdata,
    input  logic [2:0]  lu_index,
    output logic [7:0]  lu_attr
);
    sysreg_id_t        id;
    virt_ctl_t         ctl;
    route_e            route;
    logic              wr_guest, wr_hyp;
    logic [REG_W-1:0]  guest_q, hyp_q;

    assign id  = '{op0: req_op0, op1: req_op1, crn: req_crn, crm: req_crm, op2: req_op2};
    assign ctl = '{pl2_on: pl2_enabled, pl2_64: pl2_is64, host_mode: host_mode,
                   trap_rd: trap_rd_ctl, trap_wr: trap_wr_ctl, nest: nest_ctl};

    sra_route u_route (
        .id       (id),
        .is_write (req_write),
        .pl       (cur_pl),
        .ctl      (ctl),
        .route    (route)
    );

    assign wr_guest = req_valid && req_write && route == RT_GUEST;
    assign wr_hyp   = req_valid && req_write && route == RT_HYP;

    sra_regbank u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_guest   (wr_guest),
        .wr_hyp     (wr_hyp),
        .wdata      (req_wdata),
        .lu_hyp_sel (cur_pl == 2'd2 && host_mode),
        .lu_index   (lu_index),
        .guest_q    (guest_q),
        .hyp_q      (hyp_q),
        .lu_attr    (lu_attr)
    );

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_valid     <= 1'b0;
            rsp_kind      <= '0;
            rsp_rdata     <= '0;
            rsp_syndrome  <= '0;
            shadow_req    <= 1'b0;
            shadow_write  <= 1'b0;
            shadow_offset <= '0;
            shadow_wdata  <= '0;
        end else begin
            rsp_valid     <= 1'b1;
            rsp_kind      <= kind_of(route);
            rsp_syndrome  <= (route == RT_TRAP) ? TRAP_CLASS : '0;
            rsp_rdata     <= '0;
            if (!req_write && route == RT_GUEST) rsp_rdata <= guest_q;
            if (!req_write && route == RT_HYP)   rsp_rdata <= hyp_q;
            shadow_req    <= (route == RT_SHADOW);
            shadow_write  <= (route == RT_SHADOW) && req_write;
            shadow_offset <= (route == RT_SHADOW) ? SHADOW_OFS : '0;
            shadow_wdata  <= (route == RT_SHADOW && req_write) ? req_wdata : '0;
        end
    end

    // R1: level 0 never succeeds
    a_r1_pl0_undef: assert property (@(posedge clk) disable iff (rst)
        req_valid && cur_pl == 2'd0 |=> rsp_valid && rsp_kind[K_UNDEF]);
    // R9: exactly one outcome per response
    a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones(rsp_kind) == 1);
    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && rsp_kind == '0 && !shadow_req);
    // R2: traps carry the fixed class
    a_r2_syndrome: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_kind[K_TRAP] |-> rsp_syndrome == TRAP_CLASS);
    // R3: shadow port agrees with the reported outcome
    a_r3_shadow_port: assert property (@(posedge clk) disable iff (rst)
        shadow_req |-> rsp_kind[K_SHADOW] && shadow_offset == SHADOW_OFS);
    // R8: unknown identifiers never reach a register
    a_r8_unknown_id: assert property (@(posedge clk) disable iff (rst)
        req_valid && !((req_op0 == 2'b11) && (req_crn == 4'b1010) && (req_crm == 4'b0010)
                       && (req_op2 == 3'b000)) |=> rsp_kind[K_UNDEF]);
endmodule

// File: tb/test_sysreg_attr_ctrl.sv
module test_sysreg_attr_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [1:0]  req_op0;
    logic [2:0]  req_op1;
    logic [3:0]  req_crn, req_crm;
    logic [2:0]  req_op2;
    logic [63:0] req_wdata;
    logic [1:0]  cur_pl;
    logic        pl2_enabled, pl2_is64, host_mode, trap_rd_ctl, trap_wr_ctl;
    logic [2:0]  nest_ctl;
    logic        rsp_valid;
    logic [3:0]  rsp_kind;
    logic [63:0] rsp_rdata;
    logic [5:0]  rsp_syndrome;
    logic        shadow_req, shadow_write;
    logic [11:0] shadow_offset;
    logic [63:0] shadow_wdata;
    logic [2:0]  lu_index;
    logic [7:0]  lu_attr;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [63:0] m_guest, m_hyp;

    always #10 clk = ~clk;

    sysreg_attr_ctrl i_sysreg_attr_ctrl (.*);

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // outcome codes: 0 undef, 1 trap, 2 shadow, 3 guest, 4 hyp
    function automatic int model(output string tag);
        bit dir, ali, on64;
        dir = req_op0 == 2'b11 && req_crn == 4'hA && req_crm == 4'h2 && req_op2 == 3'b000 && req_op1 == 3'b000;
        ali = req_op0 == 2'b11 && req_crn == 4'hA && req_crm == 4'h2 && req_op2 == 3'b000 && req_op1 == 3'b101;
        on64 = pl2_enabled && pl2_is64;
        if (!dir && !ali) begin tag = "R8"; return 0; end
        if (cur_pl == 0) begin tag = "R1"; return 0; end
        if (dir) begin
            if (cur_pl == 1) begin
                if (on64 && (req_write ? trap_wr_ctl : trap_rd_ctl)) begin tag = "R2"; return 1; end
                if (on64 && nest_ctl == 3'b111) begin tag = "R3"; return 2; end
                tag = "R4"; return 3;
            end
            tag = "R5";
            if (cur_pl == 2 && host_mode) return 4;
            return 3;
        end
        if (cur_pl == 1) begin
            tag = "R6";
            if (pl2_enabled && nest_ctl == 3'b101) return 2;
            if (pl2_enabled && nest_ctl[0]) return 1;
            return 0;
        end
        tag = "R7";
        if (pl2_enabled && host_mode) return 3;
        return 0;
    endfunction

    task automatic drive_req(bit wr, bit alias_id, logic [1:0] pl, logic [63:0] d,
                             bit on, bit is64, bit hm, bit trd, bit twr, logic [2:0] ns);
        @(negedge clk);
        req_valid = 1; req_write = wr;
        req_op0 = 2'b11; req_op1 = alias_id ? 3'b101 : 3'b000;
        req_crn = 4'hA; req_crm = 4'h2; req_op2 = 3'b000; req_wdata = d;
        cur_pl = pl; pl2_enabled = on; pl2_is64 = is64; host_mode = hm;
        trap_rd_ctl = trd; trap_wr_ctl = twr; nest_ctl = ns;
        lu_index = 3'($urandom_range(0, 7));
    endtask

    task automatic step_check();
        string tag;
        int r;
        logic [3:0]  ek;
        logic [63:0] ed, old_g, old_h;
        logic [7:0]  eb;
        r = model(tag);
        old_g = m_guest; old_h = m_hyp;
        @(posedge clk);
        #1;
        if (!req_valid) begin
            chk(rsp_valid == 0 && rsp_kind == 0, "R9", "idle response", {60'd0, rsp_kind}, 64'd0);
        end else begin
            ek = (r == 0) ? 4'b0100 : (r == 1) ? 4'b0010 : (r == 2) ? 4'b1000 : 4'b0001;
            chk(rsp_valid && rsp_kind == ek, tag, "kind (R9)", {60'd0, rsp_kind}, {60'd0, ek});
            if (r == 1)
                chk(rsp_syndrome == 6'h18, tag, "syndrome", {58'd0, rsp_syndrome}, 64'h18);
            chk(shadow_req == (r == 2), tag, "shadow_req", {63'd0, shadow_req}, {63'd0, r == 2});
            if (r == 2) begin
                chk(shadow_offset == 12'h140 && shadow_write == req_write, tag, "shadow offset/flag",
                    {51'd0, shadow_write, shadow_offset}, {51'd0, req_write, 12'h140});
                if (req_write)
                    chk(shadow_wdata == req_wdata, tag, "shadow data", shadow_wdata, req_wdata);
            end
            if (r >= 3 && !req_write) begin
                ed = (r == 4) ? old_h : old_g;
                chk(rsp_rdata == ed, tag, "read data (R10)", rsp_rdata, ed);
            end
            if (req_write && r == 3) m_guest = req_wdata;
            if (req_write && r == 4) m_hyp   = req_wdata;
        end
        eb = (cur_pl == 2 && host_mode) ? m_hyp[lu_index*8 +: 8] : m_guest[lu_index*8 +: 8];
        chk(lu_attr == eb, "R12", "lookup byte (R10 commit)", {56'd0, lu_attr}, {56'd0, eb});
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; req_valid = 0; req_write = 0; req_op0 = 0; req_op1 = 0; req_crn = 0;
        req_crm = 0; req_op2 = 0; req_wdata = 0; cur_pl = 0; pl2_enabled = 0; pl2_is64 = 0;
        host_mode = 0; trap_rd_ctl = 0; trap_wr_ctl = 0; nest_ctl = 0; lu_index = 0;
        m_guest = 0; m_hyp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        for (int i = 0; i < 8; i++) begin
            lu_index = 3'(i);
            #1;
            chk(lu_attr == 8'h00 && rsp_valid == 0, "R11", "reset state", {55'd0, rsp_valid, lu_attr}, 64'd0);
        end

        // directed: R5 level 3 guest write, level 2 host-mode hyp write, readback
        drive_req(1, 0, 2'd3, 64'h8877665544332211, 0, 0, 0, 0, 0, 3'b000); step_check();
        drive_req(1, 0, 2'd2, 64'hF0E0D0C0B0A09080, 1, 1, 1, 0, 0, 3'b000); step_check();
        drive_req(0, 0, 2'd2, 64'd0, 1, 1, 1, 0, 0, 3'b000); step_check();
        drive_req(0, 0, 2'd1, 64'd0, 1, 1, 0, 0, 0, 3'b000); step_check();
        // R2 write trap must not commit (R10)
        drive_req(1, 0, 2'd1, 64'hDEAD, 1, 1, 0, 0, 1, 3'b000); step_check();
        drive_req(0, 0, 2'd3, 64'd0, 0, 0, 0, 0, 0, 3'b000); step_check();
        // R3 shadow write, R6 alias 101 priority over n0
        drive_req(1, 0, 2'd1, 64'h1234, 1, 1, 0, 0, 0, 3'b111); step_check();
        drive_req(1, 1, 2'd1, 64'h5678, 1, 0, 0, 0, 0, 3'b101); step_check();
        drive_req(0, 1, 2'd1, 64'd0, 1, 0, 0, 0, 0, 3'b011); step_check();
        // R7 alias at level 2 without host mode, R1 level 0
        drive_req(1, 1, 2'd2, 64'hBEEF, 1, 1, 0, 0, 0, 3'b000); step_check();
        drive_req(1, 1, 2'd0, 64'hBEEF, 1, 1, 1, 0, 0, 3'b000); step_check();
        drive_req(0, 0, 2'd3, 64'd0, 0, 0, 0, 0, 0, 3'b000); step_check();

        for (int i = 0; i < 4000; i++) begin
            int sel;
            @(negedge clk);
            sel = $urandom_range(0, 99);
            req_valid = (sel >= 5);
            req_write = 1'($urandom);
            req_op0 = 2'b11; req_crn = 4'hA; req_crm = 4'h2; req_op2 = 3'b000;
            req_op1 = (sel < 50) ? 3'b000 : 3'b101;
            if (sel >= 88) begin
                req_op0 = 2'($urandom); req_op1 = 3'($urandom); req_crn = 4'($urandom);
                req_crm = 4'($urandom); req_op2 = 3'($urandom);
            end
            req_wdata = {$urandom, $urandom};
            cur_pl = 2'($urandom);
            pl2_enabled = ($urandom_range(0, 3) != 0);
            pl2_is64 = ($urandom_range(0, 3) != 0);
            host_mode = 1'($urandom);
            trap_rd_ctl = ($urandom_range(0, 3) == 0);
            trap_wr_ctl = ($urandom_range(0, 3) == 0);
            nest_ctl = ($urandom_range(0, 2) == 0) ? 3'b000 : 3'($urandom);
            lu_index = 3'($urandom);
            step_check();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule